// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block reads a stream of 16-bit configuration halfwords, most significant byte first, one halfword for each accepted valid/ready handshake. After reset it discards everything until it has seen a 32-bit synchronization pattern. From then on it reads packet headers. A short-form (type 1) write sends each payload halfword to a 64-entry configuration register file and also shows it on a register-write strobe. A long-form (type 2) write carries a 32-bit length and then one burst of frame data, which is forwarded on a separate output strobe.

The parser also checks the order of packets. Frame data is only accepted after the frame-address register has been written. Only one burst is accepted after reset. A burst that is too short is rejected. A rejected burst is still read to its end, so the stream stays aligned, but none of it is forwarded. Protocol faults set bits in a sticky error vector. A write of a chosen code to the command register sends the parser back to searching for the synchronization pattern.

Top module: `cfg_stream_parser`

## Requirements
- R1: Until the halfword 0xAA99 is directly followed by 0x5566, accepted halfwords cause no register writes and no frame output, and `synced` stays low. `synced` goes high once 0x5566 is accepted.
- R2: A header's fields are type [15:13], opcode [12:11], register address [10:5] and halfword count [4:0]. A type-1 header with opcode 2 (write) and count N gives N `reg_we` pulses, each carrying the address, the payload halfword and its index 0..N-1. The register file then holds the last halfword written at that address, readable on `cfg_rd_data`.
- R3: A type-1 header with opcode 0 (no-op), such as 0x2000, has no payload. The next halfword is decoded as a header.
- R4: Opcodes 1 (read) and 3 (reserved) set `err_flags[0]`. The next halfword is decoded as a header.
- R5: A header whose type is neither 1 nor 2 sets `err_flags[1]`.
- R6: A type-1 write to frame-address register 1 takes its first payload halfword as `far_major` and its second as `far_minor`. Writing the second halfword marks the frame address as written.
- R7: A type-2 header with opcode 2 is followed by a length, upper halfword first then lower halfword. A valid burst then forwards that many halfwords on `frm_valid`/`frm_data`, with `frm_last` high on the final one.
- R8: After the last frame halfword, two CRC halfwords are consumed without being forwarded. The halfword after them is decoded as a header.
- R9: A burst that starts before the frame address has been written sets `err_flags[2]` and forwards nothing.
- R10: Any burst after a valid one sets `err_flags[3]` and forwards nothing.
- R11: A burst whose length is below 65 halfwords sets `err_flags[4]` and forwards nothing.
- R12: A type-1 write to command register 4 whose first halfword is 0x000D makes the parser drop `synced` and search for the synchronization pattern again.
- R13: After reset, all outputs are zero except `in_ready`, which is high from the first clock after reset. Error bits, once set, stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input halfword is valid |
| in_data | input | 16 | Input halfword |
| in_ready | output | 1 | Parser can accept a halfword |
| reg_we | output | 1 | Register-write strobe |
| reg_addr | output | 6 | Register address of the write |
| reg_idx | output | 5 | Index of the halfword within its packet |
| reg_wdata | output | 16 | Written halfword |
| frm_valid | output | 1 | Frame-data strobe |
| frm_data | output | 16 | Frame-data halfword |
| frm_last | output | 1 | Final halfword of the burst |
| far_major | output | 16 | Major frame address |
| far_minor | output | 16 | Minor frame address |
| cfg_rd_addr | input | 6 | Register file read address |
| cfg_rd_data | output | 16 | Register file read data |
| synced | output | 1 | Synchronization pattern found |
| err_flags | output | 5 | Sticky protocol error bits |

## Verification
The assertions assume that `in_valid` and `in_data` are always at defined values, and that a burst length only counts down while the parser is inside a burst. The counter-underflow check therefore depends on the length being loaded before any data halfword arrives. The stimulus changes inputs one time unit after a rising edge and presents at most one halfword per cycle. It always sends full packets, so rejected bursts are still followed by their payload and CRC halfwords. It also lets a register write reach the register file before reading it back.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int HW_W    = 16;
  localparam int RADDR_W = 6;
  localparam int RCNT_W  = 5;
  localparam int ERR_W   = 5;

  localparam int ERR_OPC   = 0;
  localparam int ERR_TYPE  = 1;
  localparam int ERR_NOFAR = 2;
  localparam int ERR_TWICE = 3;
  localparam int ERR_SHORT = 4;

  localparam logic [2:0] PT_SHORT = 3'd1;
  localparam logic [2:0] PT_LONG  = 3'd2;
  localparam logic [1:0] OP_NOP   = 2'd0;
  localparam logic [1:0] OP_WR    = 2'd2;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_PAY, ST_CNTH, ST_CNTL, ST_DATA, ST_CRC0, ST_CRC1
  } pst_e;

  function automatic logic [2:0] f_type(input logic [HW_W-1:0] h);
    return h[15:13];
  endfunction

  function automatic logic [1:0] f_op(input logic [HW_W-1:0] h);
    return h[12:11];
  endfunction

  function automatic logic [RADDR_W-1:0] f_addr(input logic [HW_W-1:0] h);
    return h[10:5];
  endfunction

  function automatic logic [RCNT_W-1:0] f_cnt(input logic [HW_W-1:0] h);
    return h[4:0];
  endfunction
endpackage

// File: rtl/cfgp_sync_hunt.sv
module cfgp_sync_hunt #(
  parameter logic [31:0] SYNC_WORD = 32'hAA995566
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [15:0] data,
  output logic        hit
);
  logic [15:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  prev_q <= '0;
    else if (en) prev_q <= data;
  end

  assign hit = en && (prev_q == SYNC_WORD[31:16]) && (data == SYNC_WORD[15:0]);
endmodule

// File: rtl/cfgp_burst_ctr.sv
module cfgp_burst_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   rem_q <= '0;
    else if (load)                rem_q <= load_val;
    else if (dec && rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign last = (rem_q == CW'(1));

  AST_CTR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> rem_q != '0); // R7
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter logic [31:0]        SYNC_WORD   = 32'hAA995566,
  parameter int                 MIN_BURST   = 65,
  parameter logic [RADDR_W-1:0] FAR_ADDR    = 6'd1,
  parameter logic [RADDR_W-1:0] CMD_ADDR    = 6'd4,
  parameter logic [HW_W-1:0]    DESYNC_CODE = 16'h000D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [HW_W-1:0]    in_data,
  output logic               in_ready,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [RCNT_W-1:0]  reg_idx,
  output logic [HW_W-1:0]    reg_wdata,
  output logic               frm_valid,
  output logic [HW_W-1:0]    frm_data,
  output logic               frm_last,
  output logic [HW_W-1:0]    far_major,
  output logic [HW_W-1:0]    far_minor,
  input  logic [RADDR_W-1:0] cfg_rd_addr,
  output logic [HW_W-1:0]    cfg_rd_data,
  output logic               synced,
  output logic [ERR_W-1:0]   err_flags
);
  localparam int LEN_W = 2 * HW_W;

  pst_e               st_q;
  logic               ready_q;
  logic [RADDR_W-1:0] pay_addr_q;
  logic [RCNT_W-1:0]  pay_left_q, pay_idx_q;
  logic [HW_W-1:0]    len_hi_q;
  logic               burst_ok_q, far_seen_q, burst_done_q, desync_q;
  logic [ERR_W-1:0]   err_q;

  // Named events used by the FSM and by the assertions.
  logic             acc, sync_hit, ctr_load, ctr_dec, ctr_last, desync_now;
  logic [LEN_W-1:0] len_now;

  assign acc        = in_valid && ready_q;
  assign len_now    = {len_hi_q, in_data};
  assign ctr_load   = acc && (st_q == ST_CNTL);
  assign ctr_dec    = acc && (st_q == ST_DATA);
  assign desync_now = (pay_addr_q == CMD_ADDR) && (pay_idx_q == '0)
                      && (in_data == DESYNC_CODE);

  cfgp_sync_hunt #(.SYNC_WORD(SYNC_WORD)) u_hunt (
    .clk(clk), .rst_n(rst_n), .en(acc && st_q == ST_HUNT),
    .data(in_data), .hit(sync_hit)
  );

  cfgp_burst_ctr #(.CW(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(len_now),
    .dec(ctr_dec), .last(ctr_last)
  );

  cfgp_regfile #(.AW(RADDR_W), .DW(HW_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
    .wdata(reg_wdata), .raddr(cfg_rd_addr), .rdata(cfg_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_HUNT;
      ready_q      <= 1'b0;
      pay_addr_q   <= '0;
      pay_left_q   <= '0;
      pay_idx_q    <= '0;
      len_hi_q     <= '0;
      burst_ok_q   <= 1'b0;
      far_seen_q   <= 1'b0;
      burst_done_q <= 1'b0;
      desync_q     <= 1'b0;
      err_q        <= '0;
      reg_we       <= 1'b0;
      reg_addr     <= '0;
      reg_idx      <= '0;
      reg_wdata    <= '0;
      frm_valid    <= 1'b0;
      frm_data     <= '0;
      frm_last     <= 1'b0;
      far_major    <= '0;
      far_minor    <= '0;
    end else begin
      ready_q   <= 1'b1;
      reg_we    <= 1'b0;
      frm_valid <= 1'b0;
      frm_last  <= 1'b0;
      if (acc) begin
        case (st_q)
          ST_HUNT: if (sync_hit) st_q <= ST_HDR;
          ST_HDR: begin
            if (f_type(in_data) == PT_SHORT) begin
              if (f_op(in_data) == OP_WR) begin
                if (f_cnt(in_data) != '0) begin
                  pay_addr_q <= f_addr(in_data);
                  pay_left_q <= f_cnt(in_data);
                  pay_idx_q  <= '0;
                  st_q       <= ST_PAY;
                end
              end else if (f_op(in_data) != OP_NOP) begin
                err_q[ERR_OPC] <= 1'b1;
              end
            end else if (f_type(in_data) == PT_LONG) begin
              if (f_op(in_data) == OP_WR) st_q <= ST_CNTH;
              else                         err_q[ERR_OPC] <= 1'b1;
            end else begin
              err_q[ERR_TYPE] <= 1'b1;
            end
          end
          ST_PAY: begin
            reg_we     <= 1'b1;
            reg_addr   <= pay_addr_q;
            reg_idx    <= pay_idx_q;
            reg_wdata  <= in_data;
            pay_idx_q  <= pay_idx_q + 1'b1;
            pay_left_q <= pay_left_q - 1'b1;
            if (pay_addr_q == FAR_ADDR) begin
              if (pay_idx_q == RCNT_W'(0)) far_major <= in_data;
              if (pay_idx_q == RCNT_W'(1)) begin
                far_minor  <= in_data;
                far_seen_q <= 1'b1;
              end
            end
            if (desync_now) desync_q <= 1'b1;
            if (pay_left_q == RCNT_W'(1)) begin
              st_q     <= (desync_q || desync_now) ? ST_HUNT : ST_HDR;
              desync_q <= 1'b0;
            end
          end
          ST_CNTH: begin
            len_hi_q <= in_data;
            st_q     <= ST_CNTL;
          end
          ST_CNTL: begin
            burst_ok_q <= 1'b0;
            if (!far_seen_q)                   err_q[ERR_NOFAR] <= 1'b1;
            else if (burst_done_q)             err_q[ERR_TWICE] <= 1'b1;
            else if (len_now < LEN_W'(MIN_BURST)) err_q[ERR_SHORT] <= 1'b1;
            else begin
              burst_ok_q   <= 1'b1;
              burst_done_q <= 1'b1;
            end
            st_q <= (len_now == '0) ? ST_CRC0 : ST_DATA;
          end
          ST_DATA: begin
            if (burst_ok_q) begin
              frm_valid <= 1'b1;
              frm_data  <= in_data;
              frm_last  <= ctr_last;
            end
            if (ctr_last) st_q <= ST_CRC0;
          end
          ST_CRC0: st_q <= ST_CRC1;
          ST_CRC1: st_q <= ST_HDR;
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign in_ready  = ready_q;
  assign synced    = (st_q != ST_HUNT);
  assign err_flags = err_q;

  AST_SYNC_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> ($past(in_data) == SYNC_WORD[15:0]) && $past(in_valid)); // R1
  AST_WE_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(st_q == ST_PAY)); // R2
  AST_FRAME_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(st_q == ST_DATA)); // R7
  AST_LAST_IS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_last |-> frm_valid); // R7
  AST_FRAME_NEEDS_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> far_seen_q && burst_done_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & $past(err_q)) == $past(err_q)); // R13
endmodule

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, reg_we, frm_valid, frm_last, synced;
  logic [5:0]  reg_addr, cfg_rd_addr;
  logic [4:0]  reg_idx, err_flags;
  logic [15:0] reg_wdata, frm_data, far_major, far_minor, cfg_rd_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_last(frm_last), .far_major(far_major),
    .far_minor(far_minor), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .synced(synced), .err_flags(err_flags)
  );

  // {data, exp_synced, exp_we, exp_addr, exp_wdata}
  typedef struct packed {
    logic [15:0] d;
    logic        s;
    logic        we;
    logic [5:0]  a;
    logic [15:0] w;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 1'b0, 1'b0, 6'd0, 16'h0000},  // R1 noise
    '{16'h30A1, 1'b0, 1'b0, 6'd0, 16'h0000},  // R1 header-like noise
    '{16'h5555, 1'b0, 1'b0, 6'd0, 16'h0000},  // R1
    '{16'hAA99, 1'b0, 1'b0, 6'd0, 16'h0000},  // R1 first half
    '{16'h5566, 1'b1, 1'b0, 6'd0, 16'h0000},  // R1 sync found
    '{16'h2000, 1'b1, 1'b0, 6'd0, 16'h0000},  // R3 no-op
    '{16'h30A2, 1'b1, 1'b0, 6'd0, 16'h0000},  // R2 write addr 5, 2 hw
    '{16'h1234, 1'b1, 1'b1, 6'd5, 16'h1234},  // R2
    '{16'hBEEF, 1'b1, 1'b1, 6'd5, 16'hBEEF},  // R2
    '{16'h2000, 1'b1, 1'b0, 6'd0, 16'h0000},  // R3
    '{16'h3062, 1'b1, 1'b0, 6'd0, 16'h0000},  // R2 write addr 3
    '{16'h0A0B, 1'b1, 1'b1, 6'd3, 16'h0A0B},  // R2
    '{16'h0C0D, 1'b1, 1'b1, 6'd3, 16'h0C0D}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Sends a long-form burst; expects forwarding only when fwd is set.
  task automatic burst(input int len, input bit fwd, input string tag);
    int seen = 0;
    push(16'h5040);
    push(16'h0000);
    push(len[15:0]);
    for (int i = 0; i < len; i++) begin
      push(16'h8000 + 16'(i));
      if (fwd) begin
        chk({tag, " data"}, {15'd0, frm_valid, frm_data}, {15'd0, 1'b1, 16'h8000 + 16'(i)});
        chk({tag, " last"}, {31'd0, frm_last}, {31'd0, (i == len - 1)});
      end else if (frm_valid) begin
        seen++;
      end
    end
    if (!fwd) chk({tag, " nothing forwarded"}, seen, 0);
    push(16'hC1C2);
    chk("R8 crc0 not forwarded", {31'd0, frm_valid}, 0);
    push(16'hC3C4);
    chk("R8 crc1 not forwarded", {31'd0, frm_valid}, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cfg_rd_addr = '0;
    idle(3);
    // R13 reset state
    chk("R13 reset synced", {31'd0, synced}, 0);
    chk("R13 reset errors", {27'd0, err_flags}, 0);
    chk("R13 reset outputs", {30'd0, reg_we, frm_valid}, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R13 ready after reset", {31'd0, in_ready}, 1);

    for (int k = 0; k < NV; k++) begin
      push(VECS[k].d);
      chk("R1 synced vector", {31'd0, synced}, {31'd0, VECS[k].s});
      chk("R2 write strobe vector", {31'd0, reg_we}, {31'd0, VECS[k].we});
      if (VECS[k].we)
        chk("R2 write addr/data vector", {10'd0, reg_addr, reg_wdata}, {10'd0, VECS[k].a, VECS[k].w});
    end
    chk("R2 last index", {27'd0, reg_idx}, 1);
    idle(1);
    cfg_rd_addr = 6'd5; #1;
    chk("R2 regfile addr5", {16'd0, cfg_rd_data}, 32'hBEEF);
    cfg_rd_addr = 6'd3; #1;
    chk("R2 regfile addr3", {16'd0, cfg_rd_data}, 32'h0C0D);

    burst(65, 1'b0, "R9 burst before address");
    chk("R9 error flag", {27'd0, err_flags}, 32'h04);

    push(16'h3022);
    push(16'h0003);
    push(16'h0007);
    chk("R6 far major", {16'd0, far_major}, 3);
    chk("R6 far minor", {16'd0, far_minor}, 7);

    burst(3, 1'b0, "R11 short burst");
    chk("R11 error flag", {27'd0, err_flags}, 32'h14);

    burst(65, 1'b1, "R7 good burst");
    chk("R7 no new error", {27'd0, err_flags}, 32'h14);
    push(16'h30A1);
    push(16'h7777);
    chk("R8 header after crc", {15'd0, reg_we, reg_wdata}, {15'd0, 1'b1, 16'h7777});

    burst(65, 1'b0, "R10 second burst");
    chk("R10 error flag", {27'd0, err_flags}, 32'h1C);

    push(16'h28A1);
    chk("R4 read opcode flag", {27'd0, err_flags}, 32'h1D);
    push(16'h30A1);
    push(16'h4444);
    chk("R4 next is header", {15'd0, reg_we, reg_wdata}, {15'd0, 1'b1, 16'h4444});

    push(16'h6000);
    chk("R5 bad type flag", {27'd0, err_flags}, 32'h1F);

    push(16'h3081);
    push(16'h000D);
    chk("R12 command write seen", {9'd0, reg_we, reg_addr, reg_wdata}, {9'd0, 1'b1, 6'd4, 16'h000D});
    chk("R12 desynced", {31'd0, synced}, 0);
    push(16'h30A1);
    push(16'h5555);
    chk("R12 ignored after desync", {31'd0, reg_we}, 0);
    idle(2);
    cfg_rd_addr = 6'd5; #1;
    chk("R1 regfile untouched while hunting", {16'd0, cfg_rd_data}, 32'h4444);
    chk("R13 errors sticky", {27'd0, err_flags}, 32'h1F);

    rst_n = 1'b0;
    idle(2);
    chk("R13 errors cleared by reset", {27'd0, err_flags}, 0);
    chk("R13 synced cleared by reset", {31'd0, synced}, 0);
    finish_run();
  end
endmodule